// File: doc/BRIEF.md
# Accelerator Control and Status Register Slave

This block is the register front end of a hardware accelerator. Software reaches it over an AXI4-Lite slave port. It launches the compute core with a start/ready handshake and tracks completion through a sticky done flag. It also keeps an interrupt status word that raises one interrupt line when enabled events occur. Five 32-bit argument words hold the first input buffer address, the second input buffer address, the output buffer address, the image height and the image width. These words drive the core directly as plain outputs.

Typical use: software writes the argument words and sets the start bit, then either polls the control word or waits for the interrupt. An idle core with no pending completion reads back as 4. After a run, software sees 6 on its first read of the control word, and that read clears the completion flag. With the auto-restart bit set, the start request stays raised across ready handshakes, so the core re-launches back to back until software clears that bit.

Top module: `acc_ctrl_regs`

## Requirements
- R1: After synchronous reset, all registers are zero: `core_start`, `irq`, `s_bvalid`, `s_rvalid` and every argument output are 0, and the interrupt status word reads 0.
- R2: The control word is at offset 0x00. Bit 0 is start, bit 1 is done, bit 2 is idle, bit 3 is ready and bit 7 is auto-restart; all other bits read 0. Writing bit 0 as 1 raises `core_start`. Writing bit 0 as 0 does not lower it. Writes to control, enable and status words take effect only when `s_wstrb[0]` is 1.
- R3: With auto-restart clear, `core_start` falls the cycle after `core_ready` is seen high while `core_start` is high.
- R4: With auto-restart set, `core_start` stays high through ready handshakes. Once software clears auto-restart, the next handshake lowers it.
- R5: Done (bit 1) is set in every cycle `core_done` is high and stays set. An accepted read of offset 0x00 clears it. If that read coincides with `core_done`, the read returns the old value and done stays set.
- R6: Idle (bit 2) and ready (bit 3) show `core_idle` and `core_ready` as they are in the cycle the read address is accepted. An idle core with no pending done reads 4, and 6 after a completion.
- R7: Interrupt status (offset 0x0C) bit 0 sets on a rising edge of `core_done` and bit 1 on a rising edge of `core_ready`, regardless of the enables. A written 1 toggles a bit. A set event in the same cycle as a toggle wins.
- R8: Offset 0x04 bit 0 is the global enable and offset 0x08 bits 1:0 are the per-event enables. `irq` is registered and equals global enable AND any(status AND enable) one cycle later.
- R9: Offsets 0x10, 0x18, 0x20, 0x28 and 0x30 hold the first input address, second input address, output address, height and width. They are read/write, each byte follows its `s_wstrb` bit, and each word drives its argument output.
- R10: Offsets 0x1C, 0x24, 0x2C, 0x34, 0x38, 0x3C and any address with nonzero bits 1:0 read 0, and writes to them change nothing.
- R11: The write address and write data may be accepted in either order or together. Only one write and one read are in flight at a time (`s_awready` and `s_wready` are low while `s_bvalid` is high). Every response is OKAY (00).
- R12: `s_bvalid` stays high until `s_bready`. `s_rvalid` and `s_rdata` hold until `s_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | Start request to the core |
| core_done | input | 1 | Core completion |
| core_idle | input | 1 | Core idle |
| core_ready | input | 1 | Core accepts start |
| arg_src1 | output | 32 | First input buffer address |
| arg_src2 | output | 32 | Second input buffer address |
| arg_dst | output | 32 | Output buffer address |
| arg_height | output | 32 | Image height |
| arg_width | output | 32 | Image width |
| irq | output | 1 | Interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the read-clear of done and a new `core_done` pulse. The bench raises `s_arvalid` for offset 0x00 on the same edge as `core_done`. It expects the read to return 4 and the next read of the control word to return 6. The second pair is a status toggle and a `core_ready` rising edge. The bench raises `core_ready` in the exact cycle the queued write to 0x0C commits, and expects the ready status bit still set afterwards.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int DATA_W        = 32;
  localparam int STRB_W        = DATA_W / 8;
  localparam int N_ARGS        = 5;
  localparam int ARG_BASE_WORD = 4;
  localparam int ARG_STEP      = 2;
  localparam int WORD_CTRL     = 0;
  localparam int WORD_GIE      = 1;
  localparam int WORD_IER      = 2;
  localparam int WORD_ISR      = 3;
  localparam int BIT_START     = 0;
  localparam int BIT_DONE      = 1;
  localparam int BIT_IDLE      = 2;
  localparam int BIT_READY     = 3;
  localparam int BIT_AUTO      = 7;
  localparam int N_EVT         = 2;
  localparam int EVT_DONE      = 0;
  localparam int EVT_READY     = 1;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [N_EVT-1:0]  evt_t;
endpackage

// File: rtl/acr_axil_wr.sv
module acr_axil_wr
  import acr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  word_t             wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output word_t             commit_data,
  output logic [STRB_W-1:0] commit_strb
);
  logic aw_held, w_held, bvalid_q;

  assign awready = !aw_held && !bvalid_q;
  assign wready  = !w_held && !bvalid_q;
  assign commit  = aw_held && w_held;
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_held     <= 1'b0;
      w_held      <= 1'b0;
      bvalid_q    <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
      commit_strb <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_held     <= 1'b1;
        commit_addr <= awaddr;
      end
      if (wvalid && wready) begin
        w_held      <= 1'b1;
        commit_data <= wdata;
        commit_strb <= wstrb;
      end
      if (commit) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acr_axil_rd.sv
module acr_axil_rd
  import acr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arvalid,
  output logic       arready,
  output word_t      rdata,
  output logic [1:0] rresp,
  output logic       rvalid,
  input  logic       rready,
  input  word_t      rd_value,
  output logic       rd_fire
);
  logic rvalid_q;

  assign arready = !rvalid_q;
  assign rd_fire = arvalid && !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata    <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rdata    <= rd_value;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acr_ctrl.sv
module acr_ctrl
  import acr_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [7:0]        wr_byte,
  input  logic              wr_lane0,
  input  logic              rd_ctrl,
  input  logic              core_done,
  input  logic              core_ready,
  output logic              core_start,
  output logic              auto_on,
  output logic              done_bit,
  output logic              gie_on,
  output evt_t              ier_bits,
  output evt_t              isr_bits,
  output logic              irq,
  output logic              start_set
);
  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(WORD_CTRL);
  localparam logic [WORD_W-1:0] W_GIE  = WORD_W'(WORD_GIE);
  localparam logic [WORD_W-1:0] W_IER  = WORD_W'(WORD_IER);
  localparam logic [WORD_W-1:0] W_ISR  = WORD_W'(WORD_ISR);

  logic byte_wr, ctrl_wr, gie_wr, ier_wr, isr_wr, handshake;
  logic done_prev, ready_prev;
  evt_t events, toggles;

  assign byte_wr   = wr_en && wr_lane0;
  assign ctrl_wr   = byte_wr && (wr_word == W_CTRL);
  assign gie_wr    = byte_wr && (wr_word == W_GIE);
  assign ier_wr    = byte_wr && (wr_word == W_IER);
  assign isr_wr    = byte_wr && (wr_word == W_ISR);
  assign start_set = ctrl_wr && wr_byte[BIT_START];
  assign handshake = core_start && core_ready;

  always_comb begin
    events            = '0;
    events[EVT_DONE]  = core_done && !done_prev;
    events[EVT_READY] = core_ready && !ready_prev;
    toggles           = isr_wr ? wr_byte[N_EVT-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_start <= 1'b0;
      auto_on    <= 1'b0;
      done_bit   <= 1'b0;
      gie_on     <= 1'b0;
      ier_bits   <= '0;
      isr_bits   <= '0;
      irq        <= 1'b0;
      done_prev  <= 1'b0;
      ready_prev <= 1'b0;
    end else begin
      done_prev  <= core_done;
      ready_prev <= core_ready;
      core_start <= start_set || (core_start && !(handshake && !auto_on));
      if (ctrl_wr) auto_on <= wr_byte[BIT_AUTO];
      done_bit   <= core_done || (done_bit && !rd_ctrl);
      if (gie_wr) gie_on <= wr_byte[0];
      if (ier_wr) ier_bits <= wr_byte[N_EVT-1:0];
      isr_bits   <= (isr_bits ^ toggles) | events;
      irq        <= gie_on && |(isr_bits & ier_bits);
    end
  end
endmodule

// File: rtl/acr_args.sv
module acr_args
  import acr_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [WORD_W-1:0]            wr_word,
  input  word_t                        wr_data,
  input  logic [STRB_W-1:0]            wr_strb,
  output logic [N_ARGS-1:0][DATA_W-1:0] args
);
  for (genvar i = 0; i < N_ARGS; i++) begin : g_arg
    localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(ARG_BASE_WORD + ARG_STEP * i);
    logic hit;
    assign hit = wr_en && (wr_word == MY_WORD);
    for (genvar b = 0; b < STRB_W; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst)
          args[i][8*b +: 8] <= '0;
        else if (hit && wr_strb[b])
          args[i][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/acc_ctrl_regs.sv
module acc_ctrl_regs
  import acr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              core_start,
  input  logic              core_done,
  input  logic              core_idle,
  input  logic              core_ready,
  output logic [31:0]       arg_src1,
  output logic [31:0]       arg_src2,
  output logic [31:0]       arg_dst,
  output logic [31:0]       arg_height,
  output logic [31:0]       arg_width,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(WORD_CTRL);
  localparam logic [WORD_W-1:0] W_GIE  = WORD_W'(WORD_GIE);
  localparam logic [WORD_W-1:0] W_IER  = WORD_W'(WORD_IER);
  localparam logic [WORD_W-1:0] W_ISR  = WORD_W'(WORD_ISR);

  logic              commit, wr_ok, rd_fire, rd_ok, rd_ctrl;
  logic [ADDR_W-1:0] commit_addr;
  word_t             commit_data, rd_value;
  logic [STRB_W-1:0] commit_strb;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              auto_on, done_bit, gie_on, start_set;
  evt_t              ier_bits, isr_bits;
  logic [N_ARGS-1:0][DATA_W-1:0] args;

  acr_axil_wr #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .commit(commit), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_strb(commit_strb)
  );

  acr_axil_rd u_rd (
    .clk(clk), .rst(rst),
    .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .rd_value(rd_value), .rd_fire(rd_fire)
  );

  assign wr_word = commit_addr[ADDR_W-1:2];
  assign wr_ok   = commit && (commit_addr[1:0] == 2'b00);
  assign rd_word = s_araddr[ADDR_W-1:2];
  assign rd_ok   = s_araddr[1:0] == 2'b00;
  assign rd_ctrl = rd_fire && rd_ok && (rd_word == W_CTRL);

  acr_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_en(wr_ok), .wr_word(wr_word), .wr_byte(commit_data[7:0]),
    .wr_lane0(commit_strb[0]), .rd_ctrl(rd_ctrl),
    .core_done(core_done), .core_ready(core_ready),
    .core_start(core_start), .auto_on(auto_on), .done_bit(done_bit),
    .gie_on(gie_on), .ier_bits(ier_bits), .isr_bits(isr_bits),
    .irq(irq), .start_set(start_set)
  );

  acr_args #(.WORD_W(WORD_W)) u_args (
    .clk(clk), .rst(rst),
    .wr_en(wr_ok), .wr_word(wr_word),
    .wr_data(commit_data), .wr_strb(commit_strb),
    .args(args)
  );

  assign arg_src1   = args[0];
  assign arg_src2   = args[1];
  assign arg_dst    = args[2];
  assign arg_height = args[3];
  assign arg_width  = args[4];

  always_comb begin
    rd_value = '0;
    if (rd_ok) begin
      if (rd_word == W_CTRL) begin
        rd_value[BIT_START] = core_start;
        rd_value[BIT_DONE]  = done_bit;
        rd_value[BIT_IDLE]  = core_idle;
        rd_value[BIT_READY] = core_ready;
        rd_value[BIT_AUTO]  = auto_on;
      end
      if (rd_word == W_GIE) rd_value[0] = gie_on;
      if (rd_word == W_IER) rd_value[N_EVT-1:0] = ier_bits;
      if (rd_word == W_ISR) rd_value[N_EVT-1:0] = isr_bits;
      for (int i = 0; i < N_ARGS; i++) begin
        if (rd_word == WORD_W'(ARG_BASE_WORD + ARG_STEP * i)) rd_value = args[i];
      end
    end
  end
endmodule

// File: rtl/acr_checker.sv
module acr_checker
  import acr_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  s_awready,
  input logic  s_wready,
  input logic  s_bvalid,
  input logic  s_bready,
  input logic  s_rvalid,
  input logic  s_rready,
  input word_t s_rdata,
  input logic  core_start,
  input logic  core_ready,
  input logic  core_done,
  input logic  irq,
  input logic  auto_on,
  input logic  start_set,
  input logic  done_bit,
  input logic  gie_on,
  input evt_t  isr_bits
);
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    core_start && core_ready && !auto_on && !start_set |=> !core_start);

  assert_auto_holds_R4: assert property (@(posedge clk) disable iff (rst)
    core_start && auto_on |=> core_start);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    core_done |=> done_bit);

  assert_ready_event_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(core_ready) |=> isr_bits[EVT_READY]);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !gie_on |=> !irq);

  assert_single_write_R11: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> !s_awready && !s_wready);

  assert_bvalid_hold_R12: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid);

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
endmodule

bind acc_ctrl_regs acr_checker u_checker (
  .clk(clk), .rst(rst),
  .s_awready(s_awready), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .core_start(core_start), .core_ready(core_ready), .core_done(core_done),
  .irq(irq), .auto_on(auto_on), .start_set(start_set),
  .done_bit(done_bit), .gie_on(gie_on), .isr_bits(isr_bits)
);

// File: tb/acc_ctrl_regs_tb.sv
module acc_ctrl_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic        core_start, irq;
  logic        core_done = 0, core_idle = 1, core_ready = 0;
  logic [31:0] arg_src1, arg_src2, arg_dst, arg_height, arg_width;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acc_ctrl_regs u_dut (.*);

  // {addr[7:0], data[31:0], strb[3:0], expected[31:0], order[1:0]}
  localparam int NV = 13;
  localparam logic [77:0] VEC [NV] = '{
    {8'h10, 32'hDEADBEEF, 4'hF, 32'hDEADBEEF, 2'd0},
    {8'h18, 32'h12345678, 4'hF, 32'h12345678, 2'd1},
    {8'h20, 32'hA5A5A5A5, 4'h3, 32'h0000A5A5, 2'd2},
    {8'h20, 32'hFFFFFFFF, 4'h8, 32'hFF00A5A5, 2'd0},
    {8'h28, 32'h00000080, 4'hF, 32'h00000080, 2'd0},
    {8'h30, 32'h00000040, 4'hF, 32'h00000040, 2'd1},
    {8'h1C, 32'hFFFFFFFF, 4'hF, 32'h00000000, 2'd0},
    {8'h34, 32'hFFFFFFFF, 4'hF, 32'h00000000, 2'd2},
    {8'h3C, 32'hFFFFFFFF, 4'hF, 32'h00000000, 2'd0},
    {8'h04, 32'hFFFFFFFF, 4'hF, 32'h00000001, 2'd0},
    {8'h08, 32'hFFFFFFFF, 4'hF, 32'h00000003, 2'd1},
    {8'h08, 32'h00000000, 4'hF, 32'h00000000, 2'd0},
    {8'h04, 32'h00000000, 4'hF, 32'h00000000, 2'd0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push();
    logic a_hs, w_hs;
    while (s_awvalid || s_wvalid) begin
      a_hs = s_awvalid && s_awready;
      w_hs = s_wvalid && s_wready;
      @(negedge clk);
      if (a_hs) s_awvalid = 0;
      if (w_hs) s_wvalid = 0;
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d,
                          input logic [3:0] st, input int ord);
    s_awaddr = a; s_wdata = d; s_wstrb = st;
    if (ord == 1) begin
      s_awvalid = 1; push(); s_wvalid = 1; push();
    end else if (ord == 2) begin
      s_wvalid = 1; push(); s_awvalid = 1; push();
    end else begin
      s_awvalid = 1; s_wvalid = 1; push();
    end
    while (!s_bvalid) @(negedge clk);
    check("R11 bresp okay", {30'd0, s_bresp}, 32'd0);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [5:0] a, output logic [31:0] d);
    s_araddr = a; s_arvalid = 1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    check("R11 rresp okay", {30'd0, s_rresp}, 32'd0);
    @(negedge clk);
  endtask

  task automatic pulse_ready();
    core_ready = 1; @(negedge clk); core_ready = 0;
  endtask

  task automatic pulse_done();
    core_done = 1; @(negedge clk); core_done = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 core_start", {31'd0, core_start}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 bvalid", {31'd0, s_bvalid}, 0);
    check("R1 rvalid", {31'd0, s_rvalid}, 0);
    check("R1 arg_src1", arg_src1, 0);
    check("R1 arg_width", arg_width, 0);
    do_read(6'h0C, rv); check("R1 isr", rv, 0);
    do_read(6'h00, rv); check("R6 idle reads 4", rv, 32'd4);

    // table of vectors: R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      v = VEC[i];
      do_write(v[75:70], v[69:38], v[37:34], int'(v[1:0]));
      do_read(v[75:70], rv);
      check($sformatf("R9 R10 R11 vector %0d", i), rv, v[33:2]);
    end
    check("R9 arg_src1 port", arg_src1, 32'hDEADBEEF);
    check("R9 arg_src2 port", arg_src2, 32'h12345678);
    check("R9 arg_dst port", arg_dst, 32'hFF00A5A5);
    check("R9 arg_height port", arg_height, 32'h80);
    check("R9 arg_width port", arg_width, 32'h40);

    // R10 misaligned access ignored
    do_write(6'h11, 32'h0, 4'hF, 0);
    check("R10 misaligned write", arg_src1, 32'hDEADBEEF);
    do_read(6'h12, rv); check("R10 misaligned read", rv, 0);

    // R2 strobe 0 ignored on control word
    do_write(6'h00, 32'h81, 4'h0, 0);
    check("R2 strobe gated start", {31'd0, core_start}, 0);
    do_read(6'h00, rv); check("R2 strobe gated ctrl", rv, 32'd4);

    // R2 R3 start handshake
    core_idle = 0;
    do_write(6'h00, 32'h1, 4'h1, 0);
    check("R2 start raised", {31'd0, core_start}, 1);
    do_read(6'h00, rv); check("R2 ctrl running", rv, 32'd1);
    do_write(6'h00, 32'h0, 4'hF, 0);
    check("R2 zero write keeps start", {31'd0, core_start}, 1);
    pulse_ready();
    check("R3 start cleared", {31'd0, core_start}, 0);
    core_idle = 1;

    // R5 R6 done sticky and read-clear
    pulse_done();
    do_read(6'h00, rv); check("R6 done reads 6", rv, 32'd6);
    do_read(6'h00, rv); check("R5 done cleared by read", rv, 32'd4);
    core_ready = 1;
    do_read(6'h00, rv); check("R6 ready bit live", rv, 32'd12);
    core_ready = 0;
    @(negedge clk);

    // R7 status events and toggles
    do_read(6'h0C, rv); check("R7 both events", rv, 32'd3);
    do_write(6'h0C, 32'h1, 4'hF, 0);
    do_read(6'h0C, rv); check("R7 toggle bit0", rv, 32'd2);
    do_write(6'h0C, 32'h3, 4'hF, 0);
    do_read(6'h0C, rv); check("R7 toggle both", rv, 32'd1);
    do_write(6'h0C, 32'h1, 4'hF, 0);
    do_read(6'h0C, rv); check("R7 cleared", rv, 32'd0);

    // R8 interrupt
    do_write(6'h08, 32'h1, 4'hF, 0);
    do_write(6'h04, 32'h1, 4'hF, 0);
    check("R8 irq idle", {31'd0, irq}, 0);
    pulse_done(); wait_n(2);
    check("R8 irq on done", {31'd0, irq}, 1);
    do_write(6'h0C, 32'h1, 4'hF, 0); wait_n(2);
    check("R8 irq after clear", {31'd0, irq}, 0);
    do_read(6'h00, rv); check("R5 done pending", rv, 32'd6);
    do_write(6'h04, 32'h0, 4'hF, 0);
    pulse_done(); wait_n(2);
    check("R8 irq masked by global", {31'd0, irq}, 0);
    do_write(6'h04, 32'h1, 4'hF, 0); wait_n(2);
    check("R8 irq after global on", {31'd0, irq}, 1);
    do_write(6'h0C, 32'h1, 4'hF, 0);
    do_read(6'h00, rv); wait_n(2);
    check("R8 irq dropped", {31'd0, irq}, 0);
    do_write(6'h08, 32'h0, 4'hF, 0);
    do_write(6'h04, 32'h0, 4'hF, 0);

    // R4 auto restart
    do_write(6'h00, 32'h81, 4'hF, 0);
    check("R4 start with auto", {31'd0, core_start}, 1);
    pulse_ready();
    check("R4 start held after handshake", {31'd0, core_start}, 1);
    do_read(6'h00, rv); check("R4 ctrl auto", rv, 32'h85);
    do_write(6'h00, 32'h0, 4'hF, 0);
    check("R2 R4 auto off start held", {31'd0, core_start}, 1);
    pulse_ready();
    check("R4 start stops", {31'd0, core_start}, 0);
    do_read(6'h00, rv); check("R4 ctrl quiet", rv, 32'd4);

    // R7 clear status before collisions
    do_read(6'h0C, rv);
    do_write(6'h0C, rv, 4'hF, 0);
    do_read(6'h0C, rv); check("R7 status flushed", rv, 0);

    // R5 collision: ctrl read accepted with core_done
    s_araddr = 6'h00; s_arvalid = 1; core_done = 1;
    @(negedge clk);
    s_arvalid = 0; core_done = 0;
    check("R5 collision read old", s_rdata, 32'd4);
    @(negedge clk);
    do_read(6'h00, rv); check("R5 done survives clear", rv, 32'd6);
    do_read(6'h00, rv); check("R5 done then cleared", rv, 32'd4);

    // R7 collision: toggle commits with ready event
    do_read(6'h0C, rv);
    do_write(6'h0C, rv, 4'hF, 0);
    do_write(6'h0C, 32'h2, 4'hF, 0);
    s_awaddr = 6'h0C; s_wdata = 32'h2; s_wstrb = 4'hF;
    s_awvalid = 1; s_wvalid = 1;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; core_ready = 1;
    @(negedge clk);
    core_ready = 0;
    while (!s_bvalid) @(negedge clk);
    @(negedge clk);
    do_read(6'h0C, rv); check("R7 event beats toggle", rv, 32'd2);

    // R12 back-pressure
    s_bready = 0;
    s_awaddr = 6'h28; s_wdata = 32'h7; s_wstrb = 4'hF;
    s_awvalid = 1; s_wvalid = 1; push();
    while (!s_bvalid) @(negedge clk);
    wait_n(3);
    check("R12 bvalid held", {31'd0, s_bvalid}, 1);
    check("R11 no new write", {31'd0, s_awready}, 0);
    s_bready = 1; @(negedge clk);
    check("R12 bvalid released", {31'd0, s_bvalid}, 0);
    s_rready = 0;
    s_araddr = 6'h28; s_arvalid = 1;
    @(negedge clk); s_arvalid = 0;
    wait_n(3);
    check("R12 rvalid held", {31'd0, s_rvalid}, 1);
    check("R12 rdata held", s_rdata, 32'h7);
    s_rready = 1; @(negedge clk);
    check("R12 rvalid released", {31'd0, s_rvalid}, 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("watchdog expired before completion");
      summary();
      $finish;
    end
  end
endmodule